// File: doc/BRIEF.md
# Two-Stage Fixed-Priority Interrupt Controller

This block merges up to fifteen external interrupt lines into one request line and one 8-bit vector for a processor. It is built from two identical eight-input units. The secondary unit's request output drives input 2 of the primary unit. Each unit captures rising edges on its inputs into pending bits. It drops lines that software has masked and chooses the pending line with the smallest index. It raises its output only when that line outranks everything the unit is already servicing.

Software programs each unit through a small write-only register port: a vector base, an eight-bit mask, and an end-of-interrupt command. The processor takes the current vector and pulses `int_ack`. The winning line then moves from pending to in-service. If the primary unit's winner is the cascade input, the secondary unit is acknowledged in the same cycle and supplies the vector. A vector is always the base, a multiple of eight, with the line index placed in bits [2:0].

Top module: `pic_cascade_top`

## Requirements
- R1: A request is captured on a rising edge of a line. A line that stays high after its acknowledge does not request again until it has gone low and high once more.
- R2: Within a unit, the unmasked pending line with the lowest index wins, so input 0 beats input 7.
- R3: The vector is {base[7:3], winning index[2:0]}. Bits [2:0] of a written base are ignored. A primary base of 32 with primary input 4 winning gives 36.
- R4: A base write with a value below 32 is rejected. The old base stays and `cfg_err` is set. A later accepted base write to the same unit clears that unit's contribution to `cfg_err`.
- R5: A masked line keeps its pending bit but cannot win. Clearing its mask bit (mask register, bit i for input i) lets it request.
- R6: A unit raises its request only when its winner has strictly higher priority (a lower index) than every line it has in service.
- R7: On `int_ack` while `int_req` is high, the winning line is set in service and its pending bit is cleared.
- R8: When the primary winner is input 2, the vector comes from the secondary unit. The acknowledge sets in-service bits in both units.
- R9: An end-of-interrupt write clears only the highest-priority in-service bit of the addressed unit. A secondary-unit interrupt needs an end-of-interrupt to the secondary and then to the primary before input 2 can request again.
- R10: If a new rising edge arrives on a line in the same cycle that the line is acknowledged, the line stays pending.
- R11: After reset `int_req` and `cfg_err` are low, the masks are clear, the primary base is 0x20 and the secondary base is 0x28.
- R12: `line_irq` bits 0 and 1 drive primary inputs 0 and 1, bits 2 to 6 drive primary inputs 3 to 7, and bits 7 to 14 drive secondary inputs 0 to 7.
- R13: Register writes use `cfg_addr[2]` to pick the unit (0 primary, 1 secondary) and `cfg_addr[1:0]` to pick the register (0 base, 1 mask, 2 end-of-interrupt with the data ignored).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_irq | input | 15 | External interrupt lines, mapped as in R12 |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Unit select and register select |
| cfg_wdata | input | 8 | Register write data |
| int_ack | input | 1 | One-cycle acknowledge from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| int_vec | output | 8 | Vector for the current request |
| cfg_err | output | 1 | A base write below 32 was rejected |

## Verification
Two things can meet in one cycle: the acknowledge that clears a line's pending bit, and a fresh rising edge on that same line. The bench provokes this by pulsing a line low and then raising it again exactly in the acknowledge cycle. It then checks that after the end-of-interrupt the line requests again with the same vector. A second pairing is the cascade: a new, higher-priority secondary request arrives while a secondary interrupt is in service. The bench confirms that the processor request stays low until both units have received their end-of-interrupt writes in order.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int N_IN      = 8;
  localparam int IDX_W     = $clog2(N_IN);
  localparam int VEC_W     = 8;
  localparam int VEC_FLOOR = 32;
  localparam int EXT_LINES = 2 * N_IN - 1;

  typedef enum logic [1:0] {
    REG_BASE = 2'd0,
    REG_MASK = 2'd1,
    REG_EOI  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // index of the lowest set bit (0 when the vector is empty)
  function automatic logic [IDX_W-1:0] lowest_idx(input logic [N_IN-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [N_IN-1:0] one_hot(input logic [IDX_W-1:0] idx);
    return N_IN'(1) << idx;
  endfunction

  function automatic logic [VEC_W-1:0] make_vec(input logic [VEC_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    return {base[VEC_W-1:IDX_W], idx};
  endfunction

  function automatic logic base_ok(input logic [VEC_W-1:0] v);
    return int'(v) >= VEC_FLOOR;
  endfunction
endpackage

// File: rtl/pic_request_reg.sv
module pic_request_reg
  import pic_pkg::*;
#(
  parameter logic [N_IN-1:0] LEVEL_MASK = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] raw_in,
  input  logic [N_IN-1:0] clr,
  output logic [N_IN-1:0] pend
);
  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] latch_q;
  logic [N_IN-1:0] rise;

  assign rise = raw_in & ~prev_q & ~LEVEL_MASK;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '0;
      latch_q <= '0;
    end else begin
      prev_q  <= raw_in;
      // a fresh edge wins over a clear in the same cycle
      latch_q <= (latch_q & ~clr) | rise;
    end
  end

  assign pend = (latch_q & ~LEVEL_MASK) | (raw_in & LEVEL_MASK);
endmodule

// File: rtl/pic_resolver.sv
module pic_resolver
  import pic_pkg::*;
(
  input  logic [N_IN-1:0]  pend,
  input  logic [N_IN-1:0]  mask,
  input  logic [N_IN-1:0]  isr,
  output logic [IDX_W-1:0] win_idx,
  output logic [IDX_W-1:0] isr_top,
  output logic             isr_any,
  output logic             raise
);
  logic [N_IN-1:0] cand;

  assign cand    = pend & ~mask;
  assign win_idx = lowest_idx(cand);
  assign isr_top = lowest_idx(isr);
  assign isr_any = |isr;
  assign raise   = (|cand) && (!isr_any || (win_idx < isr_top));
endmodule

// File: rtl/pic_unit.sv
module pic_unit
  import pic_pkg::*;
#(
  parameter logic [VEC_W-1:0] BASE_RST   = 8'h20,
  parameter logic [N_IN-1:0]  LEVEL_MASK = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  raw_in,
  input  logic             wr_base,
  input  logic             wr_mask,
  input  logic             wr_eoi,
  input  logic [VEC_W-1:0] wr_data,
  input  logic             ack_in,
  output logic             int_out,
  output logic [IDX_W-1:0] win_idx,
  output logic [VEC_W-1:0] vec_out,
  output logic             err_out,
  output logic [VEC_W-1:0] base_o,
  output logic [N_IN-1:0]  mask_o,
  output logic [N_IN-1:0]  isr_o,
  output logic             take_o,
  output logic [N_IN-1:0]  eoi_clr_o
);
  logic [VEC_W-1:0] base_q;
  logic [N_IN-1:0]  mask_q;
  logic [N_IN-1:0]  isr_q;
  logic             err_q;
  logic [N_IN-1:0]  pend;
  logic [IDX_W-1:0] isr_top;
  logic             isr_any;
  logic             take;
  logic [N_IN-1:0]  take_set;
  logic [N_IN-1:0]  eoi_clr;

  pic_request_reg #(.LEVEL_MASK(LEVEL_MASK)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .raw_in (raw_in),
    .clr    (take_set),
    .pend   (pend)
  );

  pic_resolver u_res (
    .pend    (pend),
    .mask    (mask_q),
    .isr     (isr_q),
    .win_idx (win_idx),
    .isr_top (isr_top),
    .isr_any (isr_any),
    .raise   (int_out)
  );

  assign take     = ack_in && int_out;
  assign take_set = take ? one_hot(win_idx) : '0;
  assign eoi_clr  = (wr_eoi && isr_any) ? one_hot(isr_top) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= BASE_RST;
      mask_q <= '0;
      isr_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      isr_q <= (isr_q & ~eoi_clr) | take_set;
      if (wr_mask) mask_q <= wr_data[N_IN-1:0];
      if (wr_base) begin
        if (base_ok(wr_data)) begin
          base_q <= {wr_data[VEC_W-1:IDX_W], {IDX_W{1'b0}}};
          err_q  <= 1'b0;
        end else begin
          err_q  <= 1'b1;
        end
      end
    end
  end

  assign vec_out   = make_vec(base_q, win_idx);
  assign err_out   = err_q;
  assign base_o    = base_q;
  assign mask_o    = mask_q;
  assign isr_o     = isr_q;
  assign take_o    = take;
  assign eoi_clr_o = eoi_clr;
endmodule

// File: rtl/pic_cascade_top.sv
module pic_cascade_top
  import pic_pkg::*;
#(
  parameter int               CASC_IDX = 2,
  parameter logic [VEC_W-1:0] PRI_BASE = 8'h20,
  parameter logic [VEC_W-1:0] SEC_BASE = 8'h28
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [EXT_LINES-1:0] line_irq,
  input  logic                 cfg_we,
  input  logic [2:0]           cfg_addr,
  input  logic [VEC_W-1:0]     cfg_wdata,
  input  logic                 int_ack,
  output logic                 int_req,
  output logic [VEC_W-1:0]     int_vec,
  output logic                 cfg_err
);
  localparam logic [N_IN-1:0]  CASC_BIT = N_IN'(1) << CASC_IDX;
  localparam logic [IDX_W-1:0] CASC_I   = IDX_W'(CASC_IDX);

  logic [N_IN-1:0]  pri_raw, sec_raw;
  logic             pri_int, sec_int;
  logic [IDX_W-1:0] pri_win, sec_win;
  logic [VEC_W-1:0] pri_vec, sec_vec;
  logic             pri_err, sec_err;
  logic [VEC_W-1:0] pri_base, sec_base;
  logic [N_IN-1:0]  pri_mask, sec_mask;
  logic [N_IN-1:0]  pri_isr, sec_isr;
  logic             pri_take, sec_take;
  logic [N_IN-1:0]  pri_eoi_clr, sec_eoi_clr;
  logic             sec_ack, win_is_casc;
  logic [1:0]       sel_pri, sel_sec;
  reg_sel_e         rsel;

  // external line mapping: the cascade input is skipped
  for (genvar i = 0; i < N_IN; i++) begin : g_pmap
    if (i < CASC_IDX) begin : g_lo
      assign pri_raw[i] = line_irq[i];
    end else if (i == CASC_IDX) begin : g_casc
      assign pri_raw[i] = sec_int;
    end else begin : g_hi
      assign pri_raw[i] = line_irq[i-1];
    end
  end
  assign sec_raw = line_irq[EXT_LINES-1:N_IN-1];

  assign rsel    = reg_sel_e'(cfg_addr[1:0]);
  assign sel_pri = (cfg_we && !cfg_addr[2]) ? 2'b01 : 2'b00;
  assign sel_sec = (cfg_we &&  cfg_addr[2]) ? 2'b01 : 2'b00;

  assign win_is_casc = (pri_win == CASC_I);
  assign sec_ack     = int_ack && pri_int && win_is_casc;

  pic_unit #(.BASE_RST(PRI_BASE), .LEVEL_MASK(CASC_BIT)) u_pri (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_in    (pri_raw),
    .wr_base   (sel_pri[0] && rsel == REG_BASE),
    .wr_mask   (sel_pri[0] && rsel == REG_MASK),
    .wr_eoi    (sel_pri[0] && rsel == REG_EOI),
    .wr_data   (cfg_wdata),
    .ack_in    (int_ack),
    .int_out   (pri_int),
    .win_idx   (pri_win),
    .vec_out   (pri_vec),
    .err_out   (pri_err),
    .base_o    (pri_base),
    .mask_o    (pri_mask),
    .isr_o     (pri_isr),
    .take_o    (pri_take),
    .eoi_clr_o (pri_eoi_clr)
  );

  pic_unit #(.BASE_RST(SEC_BASE), .LEVEL_MASK('0)) u_sec (
    .clk       (clk),
    .rst_n     (rst_n),
    .raw_in    (sec_raw),
    .wr_base   (sel_sec[0] && rsel == REG_BASE),
    .wr_mask   (sel_sec[0] && rsel == REG_MASK),
    .wr_eoi    (sel_sec[0] && rsel == REG_EOI),
    .wr_data   (cfg_wdata),
    .ack_in    (sec_ack),
    .int_out   (sec_int),
    .win_idx   (sec_win),
    .vec_out   (sec_vec),
    .err_out   (sec_err),
    .base_o    (sec_base),
    .mask_o    (sec_mask),
    .isr_o     (sec_isr),
    .take_o    (sec_take),
    .eoi_clr_o (sec_eoi_clr)
  );

  assign int_req = pri_int;
  assign int_vec = win_is_casc ? sec_vec : pri_vec;
  assign cfg_err = pri_err | sec_err;
endmodule

// File: rtl/pic_cascade_checker.sv
module pic_cascade_checker
  import pic_pkg::*;
#(
  parameter int CASC_IDX = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [2:0]       cfg_addr,
  input logic [VEC_W-1:0] cfg_wdata,
  input logic             cfg_err,
  input logic             int_req,
  input logic [VEC_W-1:0] pri_base,
  input logic [VEC_W-1:0] sec_base,
  input logic [N_IN-1:0]  pri_mask,
  input logic [IDX_W-1:0] pri_win,
  input logic [N_IN-1:0]  pri_isr,
  input logic [N_IN-1:0]  sec_isr,
  input logic             pri_take,
  input logic             sec_take,
  input logic [N_IN-1:0]  pri_eoi_clr
);
  localparam logic [IDX_W-1:0] CI = IDX_W'(CASC_IDX);

  assert_base_floor_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pri_base) >= VEC_FLOOR) && (int'(sec_base) >= VEC_FLOOR));

  assert_bad_base_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == 3'd0 && int'(cfg_wdata) < VEC_FLOOR)
      |=> (cfg_err && $stable(pri_base)));

  assert_masked_never_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int_req && pri_win != CI) |-> !pri_mask[pri_win]);

  assert_ack_sets_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pri_take |=> pri_isr[$past(pri_win)]);

  assert_cascade_both_service_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_take |=> (pri_isr[CASC_IDX] && (sec_isr != '0)));

  assert_eoi_clears_one_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((pri_eoi_clr != '0) && !pri_take)
      |=> ($countones(pri_isr) == $countones($past(pri_isr)) - 1));
endmodule

bind pic_cascade_top pic_cascade_checker #(.CASC_IDX(CASC_IDX)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cfg_we      (cfg_we),
  .cfg_addr    (cfg_addr),
  .cfg_wdata   (cfg_wdata),
  .cfg_err     (cfg_err),
  .int_req     (int_req),
  .pri_base    (pri_base),
  .sec_base    (sec_base),
  .pri_mask    (pri_mask),
  .pri_win     (pri_win),
  .pri_isr     (pri_isr),
  .sec_isr     (sec_isr),
  .pri_take    (pri_take),
  .sec_take    (sec_take),
  .pri_eoi_clr (pri_eoi_clr)
);

// File: tb/sim_pic_cascade_top.sv
`timescale 1ns/100ps
module sim_pic_cascade_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [14:0] line_irq = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        int_ack = 1'b0;
  logic        int_req;
  logic [7:0]  int_vec;
  logic        cfg_err;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pic_cascade_top u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_irq  (line_irq),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .int_ack   (int_ack),
    .int_req   (int_req),
    .int_vec   (int_vec),
    .cfg_err   (cfg_err)
  );

  // R12 line mapping, restated
  function automatic int pbit(input int p);
    return (p < 2) ? p : p - 1;
  endfunction
  function automatic int sbit(input int s);
    return 7 + s;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // R13 register port
  task automatic wr(input bit unit, input logic [1:0] rs, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = {unit, rs}; cfg_wdata = d;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic eoi(input bit unit);
    wr(unit, 2'd2, 8'h00);
  endtask

  task automatic set_line(input int b, input logic v);
    line_irq[b] = v;
    tick();
  endtask

  task automatic ack(input string req, input logic [7:0] exp_vec);
    chk({req, " req before ack"}, {7'd0, int_req}, 8'd1);
    chk({req, " vector"}, int_vec, exp_vec);
    int_ack = 1'b1;
    tick();
    int_ack = 1'b0;
  endtask

  task automatic t_reset();
    chk("R11 int_req", {7'd0, int_req}, 8'd0);
    chk("R11 cfg_err", {7'd0, cfg_err}, 8'd0);
    set_line(pbit(0), 1'b1);
    chk("R11 primary base", int_vec, 8'h20);
    ack("R7", 8'h20);
    chk("R7 drop after ack", {7'd0, int_req}, 8'd0);
    eoi(1'b0);
    chk("R1 held line no re-request", {7'd0, int_req}, 8'd0);
    set_line(pbit(0), 1'b0);
  endtask

  task automatic t_prio();
    line_irq[pbit(5)] = 1'b1;
    line_irq[pbit(1)] = 1'b1;
    tick();
    chk("R2 lowest index wins", int_vec, 8'h21);
    ack("R2", 8'h21);
    chk("R6 lower priority held off", {7'd0, int_req}, 8'd0);
    eoi(1'b0);
    chk("R9 after eoi next line", int_vec, 8'h25);
    ack("R9", 8'h25);
    eoi(1'b0);
    chk("R9 idle", {7'd0, int_req}, 8'd0);
    line_irq = '0;
    tick();
  endtask

  task automatic t_base();
    wr(1'b0, 2'd0, 8'h10);
    chk("R4 error set", {7'd0, cfg_err}, 8'd1);
    set_line(pbit(4), 1'b1);
    chk("R4 old base kept", int_vec, 8'h24);
    wr(1'b0, 2'd0, 8'h23);
    chk("R4 error cleared", {7'd0, cfg_err}, 8'd0);
    chk("R3 base 32 line 4", int_vec, 8'd36);
    wr(1'b0, 2'd0, 8'h40);
    chk("R3 new base", int_vec, 8'h44);
    wr(1'b1, 2'd0, 8'h1F);
    chk("R4 secondary error", {7'd0, cfg_err}, 8'd1);
    wr(1'b1, 2'd0, 8'h28);
    chk("R4 secondary error cleared", {7'd0, cfg_err}, 8'd0);
    wr(1'b0, 2'd0, 8'h20);
    ack("R3", 8'h24);
    eoi(1'b0);
    set_line(pbit(4), 1'b0);
  endtask

  task automatic t_mask();
    wr(1'b0, 2'd1, 8'h01);
    set_line(pbit(0), 1'b1);
    chk("R5 masked no request", {7'd0, int_req}, 8'd0);
    set_line(pbit(3), 1'b1);
    chk("R5 unmasked line wins", int_vec, 8'h23);
    ack("R5", 8'h23);
    eoi(1'b0);
    wr(1'b0, 2'd1, 8'h00);
    chk("R5 pending after unmask", int_vec, 8'h20);
    ack("R5", 8'h20);
    eoi(1'b0);
    chk("R5 idle", {7'd0, int_req}, 8'd0);
    line_irq = '0;
    tick();
  endtask

  task automatic t_cascade();
    set_line(sbit(5), 1'b1);
    chk("R8 cascade request", {7'd0, int_req}, 8'd1);
    chk("R12 secondary line 5 vector", int_vec, 8'h2D);
    ack("R8", 8'h2D);
    chk("R8 idle after ack", {7'd0, int_req}, 8'd0);
    set_line(sbit(1), 1'b1);
    chk("R6 cascade in service blocks", {7'd0, int_req}, 8'd0);
    eoi(1'b1);
    chk("R9 secondary eoi alone", {7'd0, int_req}, 8'd0);
    eoi(1'b0);
    chk("R9 after both eoi", int_vec, 8'h29);
    ack("R9", 8'h29);
    eoi(1'b1);
    eoi(1'b0);
    chk("R9 cascade idle", {7'd0, int_req}, 8'd0);
    line_irq = '0;
    tick();
  endtask

  task automatic t_same_cycle();
    set_line(pbit(6), 1'b1);
    set_line(pbit(6), 1'b0);
    chk("R10 pending vector", int_vec, 8'h26);
    line_irq[pbit(6)] = 1'b1;
    int_ack = 1'b1;
    tick();
    int_ack = 1'b0;
    chk("R6 own line in service", {7'd0, int_req}, 8'd0);
    eoi(1'b0);
    chk("R10 new edge kept", {7'd0, int_req}, 8'd1);
    chk("R10 vector", int_vec, 8'h26);
    ack("R10", 8'h26);
    eoi(1'b0);
    line_irq = '0;
    tick();
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    t_reset();
    t_prio();
    t_base();
    t_mask();
    t_cascade();
    t_same_cycle();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule